// File: doc/BRIEF.md
# Multi-Size TLB Translation Lookup

This block turns a 32-bit effective address into a physical address by searching two translation arrays held on chip. The first array holds many entries that each map one 4 KB page. The second array is small and fully associative, and each of its entries carries its own page-size code, so a single entry can map a region from 1 KB up to the whole address space. An entry takes part in a lookup only if it is valid, if its address-space bit equals the current space bit, and if its task tag is global or equals one of three process-ID registers.

A request strobe starts a lookup. The search over every entry of both arrays is combinational, and the result is registered, so one cycle after the strobe the block raises exactly one of a hit flag or a miss flag and presents the physical address. Software loads entries through a write port that names an array, an index and a full entry image. After reset, one entry of the variable-size array maps the top 4 KB page onto itself. This lets the first instruction fetch translate.

Top module: `tlbx_lookup`

## Requirements
- R1: After reset, the outputs are low and `rsp_pa` is 0. Variable-size entry 0 is valid with space bit 0, tag 0, page and frame numbers 0xFFFFF and size code 1, so an address in 0xFFFFF000..0xFFFFFFFF with space bit 0 hits and maps to itself. Every other address misses.
- R2: The space bit used for matching is `msr_is` when `req_fetch` is 1 and `msr_ds` when `req_fetch` is 0. An entry matches only when its stored space bit equals that bit.
- R3: An entry whose valid bit is 0 never matches.
- R4: An entry with tag 0 matches for any process IDs. An entry with a nonzero tag matches only if the tag equals `pid0`, `pid1` or `pid2`.
- R5: A variable-size entry with size code t covers 1024 << (2*t) bytes, so code 1 is 4 KB and each step multiplies the size by 4. Codes of 11 and above cover the whole 4 GB space. Fixed-size entries always cover 4 KB and ignore their size code.
- R6: Let `off` be the page-offset mask of an entry. The entry matches when (EA & ~off) equals the page number shifted left by 12. The physical address is then (frame number << 12) | (EA & off).
- R7: When several entries match, a fixed-size entry wins over any variable-size entry, and within one array the lowest index wins.
- R8: One cycle after a cycle with `req_valid` high, exactly one of `rsp_hit` and `rsp_miss` is high for that single cycle. After a cycle without a request, both flags are low and `rsp_pa` keeps its value.
- R9: A write with `wr_en` high stores the entry image at `wr_idx` in the variable-size array when `wr_var` is 1, and in the fixed-size array when `wr_var` is 0. A variable-size write whose index is 16 or more is ignored. A lookup in the same cycle as a write sees the contents from before the write.
- R10: On a miss, `rsp_pa` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_ea | input | 32 | Effective address to translate |
| req_fetch | input | 1 | 1 selects an instruction fetch, 0 selects a data access |
| msr_is | input | 1 | Instruction address-space bit |
| msr_ds | input | 1 | Data address-space bit |
| pid0 | input | 8 | Process-ID register 0 |
| pid1 | input | 8 | Process-ID register 1 |
| pid2 | input | 8 | Process-ID register 2 |
| wr_en | input | 1 | Entry write strobe |
| wr_var | input | 1 | 1 selects the variable-size array, 0 selects the fixed-size array |
| wr_idx | input | 8 | Entry index to write |
| wr_valid | input | 1 | Entry valid bit |
| wr_ts | input | 1 | Entry address-space bit |
| wr_tid | input | 8 | Entry task tag, 0 means global |
| wr_epn | input | 20 | Entry effective page number |
| wr_rpn | input | 20 | Entry real frame number |
| wr_tsize | input | 4 | Entry page-size code |
| wr_perm | input | 6 | Entry permission bits, stored only |
| wr_wimge | input | 5 | Entry storage attributes, stored only |
| wr_iprot | input | 1 | Entry invalidation-protect bit, stored only |
| rsp_pa | output | 32 | Translated physical address |
| rsp_hit | output | 1 | Lookup hit, one cycle after the request |
| rsp_miss | output | 1 | Lookup miss, one cycle after the request |

## Verification
A lookup and an entry write can fall in the same cycle, either to the entry the lookup would hit or to one that would newly cover its address. The bench provokes this in directed cases and at random. It writes an entry that would hit while it looks up the same address. It expects a miss, or the old mapping, in that cycle and the new mapping one cycle later. Its reference model computes each expected result from the array contents before it applies the write of that cycle.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;

  localparam int EA_W   = 32;
  localparam int PN_W   = 20;
  localparam int TID_W  = 8;
  localparam int TSZ_W  = 4;
  localparam int PERM_W = 6;
  localparam int ATTR_W = 5;
  localparam int OFF4K  = EA_W - PN_W;

  typedef struct packed {
    logic              valid;
    logic              ts;
    logic [TID_W-1:0]  tid;
    logic [PN_W-1:0]   epn;
    logic [PN_W-1:0]   rpn;
    logic [TSZ_W-1:0]  tsize;
    logic [PERM_W-1:0] perm;
    logic [ATTR_W-1:0] wimge;
    logic              iprot;
  } tlb_ent_t;

  // Entry mapping the last 4 KB page onto itself, present after reset.
  localparam tlb_ent_t BOOT_ENT = '{
    valid: 1'b1, ts: 1'b0, tid: '0,
    epn: '1, rpn: '1, tsize: TSZ_W'(1),
    perm: PERM_W'(6'b010101), wimge: ATTR_W'(5'h08), iprot: 1'b1
  };

  // Low-bit mask of the page offset for a given size code.
  function automatic logic [EA_W-1:0] var_off_mask(input logic [TSZ_W-1:0] tsize);
    logic [7:0] sh;
    sh = 8'd10 + {3'b000, tsize, 1'b0};
    if (sh >= 8'(EA_W)) return '1;
    return (EA_W'(1) << sh) - EA_W'(1);
  endfunction

  function automatic logic [EA_W-1:0] fix_off_mask();
    return (EA_W'(1) << OFF4K) - EA_W'(1);
  endfunction

  function automatic logic [EA_W-1:0] pn_to_addr(input logic [PN_W-1:0] pn);
    return {pn, {OFF4K{1'b0}}};
  endfunction

  function automatic logic [EA_W-1:0] make_pa(input logic [PN_W-1:0] rpn,
                                              input logic [EA_W-1:0] ea,
                                              input logic [EA_W-1:0] off);
    return pn_to_addr(rpn) | (ea & off);
  endfunction

endpackage

// File: rtl/tlbx_match_unit.sv
module tlbx_match_unit
  import tlbx_pkg::*;
#(
  parameter bit FIXED_4K = 1'b1
) (
  input  tlb_ent_t         ent,
  input  logic [EA_W-1:0]  ea,
  input  logic             as_bit,
  input  logic [TID_W-1:0] pid0,
  input  logic [TID_W-1:0] pid1,
  input  logic [TID_W-1:0] pid2,
  output logic             hit,
  output logic [EA_W-1:0]  pa
);

  logic [EA_W-1:0] off;
  logic            tid_ok;
  logic            addr_ok;

  generate
    if (FIXED_4K) begin : g_fix
      assign off = fix_off_mask();
    end else begin : g_var
      assign off = var_off_mask(ent.tsize);
    end
  endgenerate

  assign tid_ok  = (ent.tid == '0) || (ent.tid == pid0) ||
                   (ent.tid == pid1) || (ent.tid == pid2);
  assign addr_ok = (ea & ~off) == pn_to_addr(ent.epn);
  assign hit     = ent.valid && (ent.ts == as_bit) && tid_ok && addr_ok;
  assign pa      = make_pa(ent.rpn, ea, off);

endmodule

// File: rtl/tlbx_first_hit.sv
module tlbx_first_hit
  import tlbx_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]           hits,
  input  logic [N-1:0][EA_W-1:0] pas,
  output logic                   any,
  output logic [EA_W-1:0]        pa
);

  always_comb begin
    any = 1'b0;
    pa  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        pa  = pas[i];
      end
    end
  end

endmodule

// File: rtl/tlbx_array.sv
module tlbx_array
  import tlbx_pkg::*;
#(
  parameter int N        = 16,
  parameter int IN_W     = 8,
  parameter bit FIXED_4K = 1'b0,
  parameter bit HAS_BOOT = 1'b0,
  localparam int IDX_W   = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IN_W-1:0]  wr_idx,
  input  tlb_ent_t         wr_ent,
  input  logic [EA_W-1:0]  ea,
  input  logic             as_bit,
  input  logic [TID_W-1:0] pid0,
  input  logic [TID_W-1:0] pid1,
  input  logic [TID_W-1:0] pid2,
  output logic             any_hit,
  output logic [EA_W-1:0]  hit_pa
);

  tlb_ent_t              ent_q [N];
  logic [N-1:0]          hits;
  logic [N-1:0][EA_W-1:0] pas;
  logic                  idx_ok;

  assign idx_ok = {1'b0, wr_idx} < (IN_W + 1)'(N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        ent_q[i] <= (HAS_BOOT && i == 0) ? BOOT_ENT : tlb_ent_t'('0);
      end
    end else if (wr_en && idx_ok) begin
      ent_q[wr_idx[IDX_W-1:0]] <= wr_ent;
    end
  end

  generate
    for (genvar g = 0; g < N; g++) begin : g_ent
      tlbx_match_unit #(.FIXED_4K(FIXED_4K)) u_match (
        .ent    (ent_q[g]),
        .ea     (ea),
        .as_bit (as_bit),
        .pid0   (pid0),
        .pid1   (pid1),
        .pid2   (pid2),
        .hit    (hits[g]),
        .pa     (pas[g])
      );
    end
  endgenerate

  tlbx_first_hit #(.N(N)) u_pick (
    .hits (hits),
    .pas  (pas),
    .any  (any_hit),
    .pa   (hit_pa)
  );

endmodule

// File: rtl/tlbx_lookup.sv
module tlbx_lookup
  import tlbx_pkg::*;
#(
  parameter int FIX_ENTRIES = 256,
  parameter int VAR_ENTRIES = 16,
  localparam int WIDX_W     = $clog2(FIX_ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_ea,
  input  logic              req_fetch,
  input  logic              msr_is,
  input  logic              msr_ds,
  input  logic [7:0]        pid0,
  input  logic [7:0]        pid1,
  input  logic [7:0]        pid2,
  input  logic              wr_en,
  input  logic              wr_var,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic              wr_valid,
  input  logic              wr_ts,
  input  logic [7:0]        wr_tid,
  input  logic [19:0]       wr_epn,
  input  logic [19:0]       wr_rpn,
  input  logic [3:0]        wr_tsize,
  input  logic [5:0]        wr_perm,
  input  logic [4:0]        wr_wimge,
  input  logic              wr_iprot,
  output logic [31:0]       rsp_pa,
  output logic              rsp_hit,
  output logic              rsp_miss
);

  tlb_ent_t        wr_ent;
  logic            as_bit;
  logic            fix_hit;
  logic            var_hit;
  logic [EA_W-1:0] fix_pa;
  logic [EA_W-1:0] var_pa;
  logic            any_hit;
  logic [EA_W-1:0] sel_pa;

  assign wr_ent = '{valid: wr_valid, ts: wr_ts, tid: wr_tid, epn: wr_epn,
                    rpn: wr_rpn, tsize: wr_tsize, perm: wr_perm,
                    wimge: wr_wimge, iprot: wr_iprot};

  assign as_bit = req_fetch ? msr_is : msr_ds;

  tlbx_array #(
    .N(FIX_ENTRIES), .IN_W(WIDX_W), .FIXED_4K(1'b1), .HAS_BOOT(1'b0)
  ) u_fix (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && !wr_var), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .ea(req_ea), .as_bit(as_bit), .pid0(pid0), .pid1(pid1), .pid2(pid2),
    .any_hit(fix_hit), .hit_pa(fix_pa)
  );

  tlbx_array #(
    .N(VAR_ENTRIES), .IN_W(WIDX_W), .FIXED_4K(1'b0), .HAS_BOOT(1'b1)
  ) u_var (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en && wr_var), .wr_idx(wr_idx), .wr_ent(wr_ent),
    .ea(req_ea), .as_bit(as_bit), .pid0(pid0), .pid1(pid1), .pid2(pid2),
    .any_hit(var_hit), .hit_pa(var_pa)
  );

  assign any_hit = fix_hit || var_hit;
  assign sel_pa  = fix_hit ? fix_pa : (var_hit ? var_pa : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_pa   <= '0;
      rsp_hit  <= 1'b0;
      rsp_miss <= 1'b0;
    end else begin
      rsp_hit  <= req_valid && any_hit;
      rsp_miss <= req_valid && !any_hit;
      if (req_valid) rsp_pa <= sel_pa;
    end
  end

endmodule

// File: rtl/tlbx_lookup_chk.sv
module tlbx_lookup_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_ea,
  input logic        fix_hit,
  input logic        var_hit,
  input logic [31:0] fix_pa,
  input logic [31:0] rsp_pa,
  input logic        rsp_hit,
  input logic        rsp_miss
);

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, rsp_miss}));

  p_resp_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit || rsp_miss));

  p_quiet_without_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_hit && !rsp_miss && $stable(rsp_pa)));

  p_miss_pa_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> (rsp_pa == 32'h0));

  p_fixed_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fix_hit) |=> (rsp_hit && rsp_pa == $past(fix_pa)));

  p_hit_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_hit == $past(fix_hit || var_hit)));

  p_fixed_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fix_hit) |=> (rsp_pa[11:0] == $past(req_ea[11:0])));

endmodule

bind tlbx_lookup tlbx_lookup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
  .fix_hit(fix_hit), .var_hit(var_hit), .fix_pa(fix_pa),
  .rsp_pa(rsp_pa), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss)
);

// File: tb/tlbx_lookup_bench.sv
module tlbx_lookup_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NFIX = 256;
  localparam int NVAR = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_fetch = 0, msr_is = 0, msr_ds = 0;
  logic [31:0] req_ea = 0;
  logic [7:0]  pid0 = 0, pid1 = 0, pid2 = 0;
  logic        wr_en = 0, wr_var = 0, wr_valid = 0, wr_ts = 0, wr_iprot = 0;
  logic [7:0]  wr_idx = 0, wr_tid = 0;
  logic [19:0] wr_epn = 0, wr_rpn = 0;
  logic [3:0]  wr_tsize = 0;
  logic [5:0]  wr_perm = 0;
  logic [4:0]  wr_wimge = 0;
  logic [31:0] rsp_pa;
  logic        rsp_hit, rsp_miss;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlbx_lookup u_tlbx_lookup (
    .clk, .rst_n, .req_valid, .req_ea, .req_fetch, .msr_is, .msr_ds,
    .pid0, .pid1, .pid2, .wr_en, .wr_var, .wr_idx, .wr_valid, .wr_ts,
    .wr_tid, .wr_epn, .wr_rpn, .wr_tsize, .wr_perm, .wr_wimge, .wr_iprot,
    .rsp_pa, .rsp_hit, .rsp_miss
  );

  typedef struct {
    bit          v;
    bit          ts;
    bit [7:0]    tid;
    bit [19:0]   epn;
    bit [19:0]   rpn;
    int unsigned tsz;
  } mdl_ent_t;

  mdl_ent_t fx[NFIX];
  mdl_ent_t vr[NVAR];
  int checks = 0, failures = 0;
  bit [31:0] last_pa = 0;

  // Offset span of an entry computed by repeated multiplication.
  function automatic bit [31:0] span_lo(input bit is_var, input int unsigned tsz);
    longint unsigned sz;
    if (!is_var) return 32'h0000_0FFF;
    sz = 1024;
    for (int k = 0; k < int'(tsz); k++) sz = sz * 4;
    if (sz >= 64'h1_0000_0000) return 32'hFFFF_FFFF;
    return 32'(sz - 1);
  endfunction

  function automatic bit ent_ok(input mdl_ent_t e, input bit is_var,
                                input bit [31:0] ea, input bit asb);
    bit [31:0] lo;
    if (!e.v) return 0;
    if (e.ts != asb) return 0;
    if (e.tid != 0 && e.tid != pid0 && e.tid != pid1 && e.tid != pid2) return 0;
    lo = span_lo(is_var, e.tsz);
    return (ea & ~lo) == {e.epn, 12'h000};
  endfunction

  task automatic ref_lookup(output bit hit, output bit [31:0] pa);
    bit asb;
    asb = req_fetch ? msr_is : msr_ds;
    hit = 0;
    pa = 0;
    for (int i = 0; i < NFIX; i++) begin
      if (!hit && ent_ok(fx[i], 0, req_ea, asb)) begin
        hit = 1;
        pa = {fx[i].rpn, 12'h000} | (req_ea & 32'h0000_0FFF);
      end
    end
    for (int i = 0; i < NVAR; i++) begin
      if (!hit && ent_ok(vr[i], 1, req_ea, asb)) begin
        hit = 1;
        pa = {vr[i].rpn, 12'h000} | (req_ea & span_lo(1, vr[i].tsz));
      end
    end
  endtask

  task automatic check(input string tag, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // One cycle: compute expectations from current inputs, wait, check, commit write.
  task automatic tick(input string tag);
    bit ehit;
    bit [31:0] epa;
    ref_lookup(ehit, epa);
    @(negedge clk);
    if (req_valid) begin
      check({tag, " hit"}, {31'b0, rsp_hit}, {31'b0, ehit});
      check({tag, " miss"}, {31'b0, rsp_miss}, {31'b0, !ehit});
      check({tag, " pa"}, rsp_pa, ehit ? epa : 32'h0);
      last_pa = ehit ? epa : 32'h0;
    end else begin
      check({tag, " idle R8"}, {30'b0, rsp_hit, rsp_miss}, 32'h0);
      check({tag, " hold R8"}, rsp_pa, last_pa);
    end
    if (wr_en) begin
      mdl_ent_t e;
      e = '{v: wr_valid, ts: wr_ts, tid: wr_tid, epn: wr_epn, rpn: wr_rpn, tsz: wr_tsize};
      if (!wr_var) fx[wr_idx] = e;
      else if (wr_idx < NVAR) vr[wr_idx] = e;
    end
    wr_en = 0;
    req_valid = 0;
  endtask

  task automatic set_wr(input bit sel, input int idx, input bit v, input bit ts,
                        input bit [7:0] tid, input bit [19:0] epn,
                        input bit [19:0] rpn, input bit [3:0] tsz);
    wr_en = 1; wr_var = sel; wr_idx = 8'(idx); wr_valid = v; wr_ts = ts;
    wr_tid = tid; wr_epn = epn; wr_rpn = rpn; wr_tsize = tsz;
    wr_perm = 6'($urandom); wr_wimge = 5'($urandom); wr_iprot = 1'($urandom);
  endtask

  task automatic set_req(input bit [31:0] ea, input bit fetch, input bit isb, input bit dsb);
    req_valid = 1; req_ea = ea; req_fetch = fetch; msr_is = isb; msr_ds = dsb;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NFIX; i++) fx[i] = '{v: 0, ts: 0, tid: 0, epn: 0, rpn: 0, tsz: 0};
    for (int i = 0; i < NVAR; i++) vr[i] = '{v: 0, ts: 0, tid: 0, epn: 0, rpn: 0, tsz: 0};
    vr[0] = '{v: 1, ts: 0, tid: 0, epn: 20'hFFFFF, rpn: 20'hFFFFF, tsz: 1};

    repeat (3) @(negedge clk);
    check("R1 reset hit", {31'b0, rsp_hit}, 0);
    check("R1 reset miss", {31'b0, rsp_miss}, 0);
    check("R1 reset pa", rsp_pa, 0);
    rst_n = 1;

    // R1 boot page maps to itself; R2 space bit selection
    set_req(32'hFFFF_F123, 0, 1, 0); tick("R1 boot data");
    set_req(32'hFFFF_FFFC, 1, 0, 1); tick("R2 boot fetch is=0");
    set_req(32'hFFFF_FFFC, 1, 1, 0); tick("R2 boot fetch is=1");
    set_req(32'hFFFF_E000, 0, 0, 0); tick("R1 below boot page");
    set_req(32'h0000_1000, 0, 0, 0); tick("R10 miss pa zero");
    tick("R8 idle");

    // R6 basic fixed mapping
    set_wr(0, 5, 1, 0, 0, 20'h00010, 20'h12345, 4'd0); tick("R9 write fx5");
    set_req(32'h0001_0ABC, 0, 0, 0); tick("R6 fx5 map");
    // R9 write and lookup in the same cycle
    set_wr(0, 6, 1, 0, 0, 20'h00020, 20'h2AAAA, 4'd0);
    set_req(32'h0002_0004, 0, 0, 0); tick("R9 same cycle old");
    set_req(32'h0002_0004, 0, 0, 0); tick("R9 next cycle new");
    // R7 priority
    set_wr(1, 3, 1, 0, 0, 20'h00010, 20'h55555, 4'd1); tick("R9 write vr3");
    set_req(32'h0001_0ABC, 0, 0, 0); tick("R7 fixed over var");
    set_wr(0, 2, 1, 0, 0, 20'h00010, 20'h0AAAA, 4'd0); tick("R9 write fx2");
    set_req(32'h0001_0ABC, 0, 0, 0); tick("R7 lowest index");
    // R4 tag matching
    set_wr(0, 9, 1, 0, 8'h42, 20'h00300, 20'h00777, 4'd0); tick("R9 write fx9");
    set_req(32'h0030_0010, 0, 0, 0); tick("R4 tag no pid");
    pid1 = 8'h42;
    set_req(32'h0030_0010, 0, 0, 0); tick("R4 tag pid1");
    pid1 = 0; pid2 = 8'h42;
    set_req(32'h0030_0010, 0, 0, 0); tick("R4 tag pid2");
    // R3 invalid entry
    set_wr(0, 9, 0, 0, 0, 20'h00300, 20'h00777, 4'd0); tick("R9 clear fx9");
    set_req(32'h0030_0010, 0, 0, 0); tick("R3 invalid");
    // R5 page sizes
    set_wr(1, 1, 1, 0, 0, 20'h40000, 20'h80000, 4'd3); tick("R9 write vr1");
    set_req(32'h4000_ABCD, 0, 0, 0); tick("R5 64KB inside");
    set_req(32'h4001_0000, 0, 0, 0); tick("R5 64KB outside");
    set_wr(0, 10, 1, 0, 0, 20'h50000, 20'h60000, 4'd5); tick("R9 write fx10");
    set_req(32'h5000_0FFF, 0, 0, 0); tick("R5 fixed 4KB inside");
    set_req(32'h5000_1000, 0, 0, 0); tick("R5 fixed ignores tsize");
    set_wr(1, 2, 1, 1, 0, 20'h00000, 20'h00000, 4'd12); tick("R9 write vr2");
    set_req(32'h9876_5432, 1, 1, 0); tick("R5 whole space");
    // R9 out-of-range variable index
    set_wr(1, 20, 1, 0, 0, 20'h60000, 20'h70000, 4'd1); tick("R9 var idx 20");
    set_req(32'h6000_0000, 0, 0, 0); tick("R9 var idx ignored");

    // Random mix with same-cycle writes and lookups
    for (int n = 0; n < 3000; n++) begin
      pid0 = 8'($urandom_range(0, 3));
      pid1 = 8'($urandom_range(0, 3));
      pid2 = 8'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) begin
        bit sel;
        sel = 1'($urandom_range(0, 3) == 0);
        set_wr(sel, sel ? $urandom_range(0, 19) : $urandom_range(0, NFIX - 1),
               1'($urandom_range(0, 5) != 0), 1'($urandom),
               8'($urandom_range(0, 3)),
               20'({$urandom_range(0, 3), 16'h0} | $urandom_range(0, 7)),
               20'($urandom), 4'($urandom_range(0, 12)));
      end
      if ($urandom_range(0, 4) != 0) begin
        bit [31:0] ea;
        ea = {12'($urandom_range(0, 3) << 4), 20'h0} |
             32'($urandom_range(0, 7) << 12) | 32'($urandom_range(0, 32'h3FFF));
        if ($urandom_range(0, 7) == 0) ea = $urandom;
        set_req(ea, 1'($urandom), 1'($urandom), 1'($urandom));
      end
      tick("R6 R7 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule